// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block sits next to a processor's program counter and runs counted loops with no branch instructions. It holds two loop contexts. Each context has a start address, an end address and a repeat count. On every fetch it compares the fetch address with both end addresses. In the same cycle it returns the address to fetch next: either the loop start or the sequential successor.

When a loop-back is taken, the repeat count of the chosen context drops by one at the next clock edge. Once the count is zero, the end address falls through and that loop stays idle until it is loaded again. The two contexts may share one end address. In that case context 1 is the inner loop, and context 0 only loops back when context 1 does not.

Software loads a context in one of two ways. A setup request writes the start and end addresses in one operation and may also write the count. The setup request is accepted only when both addresses lie inside a bounded forward window from the address of the setup instruction. A plain write port updates one register at a time.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset every repeat count is zero, `redirect` is low, `setup_err` is low, and a valid fetch at any address yields `next_pc` = `fetch_pc`+1.
- R2: A valid fetch whose address equals a context's end address, while that context's count is nonzero, drives `redirect` high and `next_pc` to that context's start address in the same cycle. The count drops by one at the following clock edge.
- R3: A valid fetch at an end address whose count is zero gives `redirect` low and `next_pc` = end+1. The loop stays idle on later visits until it is reloaded.
- R4: A context whose start and end addresses are equal forms a one-instruction loop that repeats that address count times and then falls through.
- R5: When both contexts hold the same end address, context 1 is evaluated first. Context 0 loops back only when context 1's count is zero.
- R6: When the end addresses differ, only the context whose end address matches the fetch address loops back or decrements.
- R7: An accepted setup writes the start and end of context `setup_idx`. It writes `setup_cnt` only when `setup_cnt_en` is 1; otherwise the previous count is kept.
- R8: A setup is accepted only if (start − `setup_pc`) mod 2^ADDR_W lies in 1..TOP_SPAN and (end − `setup_pc`) mod 2^ADDR_W lies between that start offset and BOT_SPAN (defaults 31 and 1023). A rejected setup leaves all registers unchanged and pulses `setup_err` high for exactly the following cycle.
- R9: The write port selects a register with `wr_sel`: 0 writes the start, 1 writes the end, 2 writes the count of context `wr_idx`. The value 3 writes nothing.
- R10: While `fetch_valid` is low, `redirect` is low, `next_pc` = `fetch_pc`+1 and no count changes.
- R11: A write or setup to a context in the same cycle as a loop-back on that context takes priority over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | ADDR_W | Current fetch address |
| next_pc | output | ADDR_W | Next fetch address (combinational) |
| redirect | output | 1 | A loop-back is taken this cycle |
| setup_valid | input | 1 | Setup request |
| setup_idx | input | 1 | Context loaded by setup |
| setup_pc | input | ADDR_W | Address of the setup instruction |
| setup_top | input | ADDR_W | Requested loop start address |
| setup_bot | input | ADDR_W | Requested loop end address |
| setup_cnt_en | input | 1 | Setup also writes the count |
| setup_cnt | input | CNT_W | Count written by setup |
| setup_err | output | 1 | Previous-cycle setup was rejected |
| wr_en | input | 1 | Single-register write strobe |
| wr_idx | input | 1 | Context written |
| wr_sel | input | 2 | 0 start, 1 end, 2 count, 3 none |
| wr_data | input | DATA_W | Write value |

## Verification
The hardest state to reach is a shared end address with both counts still live, followed by context 1 running out while context 0 still has a repeat left. The stimulus loads both contexts through setup with a common end address and counts of 2 and 1. It then fetches that address four times, and expects three loop-backs and then a fall-through: inner, inner, outer, exit.

The second hard case is a rejected setup aimed at a context whose count is nonzero. The retained count is observed as a loop-back in the same cycle that the error pulse is sampled.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    localparam int NUM_CTX = 2;
    localparam int IDX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

    typedef enum logic [1:0] {
        WSEL_TOP  = 2'd0,
        WSEL_BOT  = 2'd1,
        WSEL_CNT  = 2'd2,
        WSEL_NONE = 2'd3
    } wr_sel_e;

endpackage

// File: rtl/hwl_end_match.sv
module hwl_end_match #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [CNT_W-1:0]  count,
    output logic              hit,
    output logic              live
);
    always_comb begin
        hit  = (pc == end_addr);
        live = (count != '0);
    end
endmodule

// File: rtl/hwl_pick.sv
module hwl_pick
    import hwloop_pkg::*;
(
    input  logic               valid,
    input  logic [NUM_CTX-1:0] hit,
    input  logic [NUM_CTX-1:0] live,
    output logic               take,
    output logic [IDX_W-1:0]   take_idx
);
    // Highest index is the innermost loop and wins.
    always_comb begin
        take     = 1'b0;
        take_idx = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (valid && hit[i] && live[i]) begin
                take     = 1'b1;
                take_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/hwl_span_check.sv
module hwl_span_check #(
    parameter int ADDR_W   = 16,
    parameter int TOP_SPAN = 31,
    parameter int BOT_SPAN = 1023
) (
    input  logic [ADDR_W-1:0] base_pc,
    input  logic [ADDR_W-1:0] top,
    input  logic [ADDR_W-1:0] bot,
    output logic              ok
);
    logic [ADDR_W-1:0] top_ofs;
    logic [ADDR_W-1:0] bot_ofs;

    always_comb begin
        top_ofs = top - base_pc;
        bot_ofs = bot - base_pc;
        ok = (top_ofs >= ADDR_W'(1))
          && (top_ofs <= ADDR_W'(TOP_SPAN))
          && (bot_ofs >= top_ofs)
          && (bot_ofs <= ADDR_W'(BOT_SPAN));
    end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 16,
    parameter int TOP_SPAN = 31,
    parameter int BOT_SPAN = 1023,
    localparam int DATA_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              redirect,
    input  logic              setup_valid,
    input  logic [IDX_W-1:0]  setup_idx,
    input  logic [ADDR_W-1:0] setup_pc,
    input  logic [ADDR_W-1:0] setup_top,
    input  logic [ADDR_W-1:0] setup_bot,
    input  logic              setup_cnt_en,
    input  logic [CNT_W-1:0]  setup_cnt,
    output logic              setup_err,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] top;
        logic [ADDR_W-1:0] bot;
        logic [CNT_W-1:0]  cnt;
    } ctx_t;

    typedef struct packed {
        ctx_t [NUM_CTX-1:0] ctx;
        logic               err;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_CTX-1:0] hit, live;
    logic               take;
    logic [IDX_W-1:0]   take_idx;
    logic               setup_ok;
    wr_sel_e            sel;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_match
        hwl_end_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
            .pc       (fetch_pc),
            .end_addr (state_q.ctx[g].bot),
            .count    (state_q.ctx[g].cnt),
            .hit      (hit[g]),
            .live     (live[g])
        );
    end

    hwl_pick u_pick (
        .valid    (fetch_valid),
        .hit      (hit),
        .live     (live),
        .take     (take),
        .take_idx (take_idx)
    );

    hwl_span_check #(.ADDR_W(ADDR_W), .TOP_SPAN(TOP_SPAN), .BOT_SPAN(BOT_SPAN)) u_span (
        .base_pc (setup_pc),
        .top     (setup_top),
        .bot     (setup_bot),
        .ok      (setup_ok)
    );

    always_comb begin
        sel      = wr_sel_e'(wr_sel);
        redirect = take;
        next_pc  = fetch_pc + ADDR_W'(1);
        for (int i = 0; i < NUM_CTX; i++) begin
            if (take && take_idx == IDX_W'(i)) begin
                next_pc = state_q.ctx[i].top;
            end
        end
    end

    always_comb begin
        state_d     = state_q;
        state_d.err = setup_valid && !setup_ok;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (take && take_idx == IDX_W'(i)) begin
                state_d.ctx[i].cnt = state_q.ctx[i].cnt - CNT_W'(1);
            end
            if (wr_en && wr_idx == IDX_W'(i)) begin
                case (sel)
                    WSEL_TOP:  state_d.ctx[i].top = wr_data[ADDR_W-1:0];
                    WSEL_BOT:  state_d.ctx[i].bot = wr_data[ADDR_W-1:0];
                    WSEL_CNT:  state_d.ctx[i].cnt = wr_data[CNT_W-1:0];
                    WSEL_NONE: ;
                    default:   ;
                endcase
            end
            if (setup_valid && setup_ok && setup_idx == IDX_W'(i)) begin
                state_d.ctx[i].top = setup_top;
                state_d.ctx[i].bot = setup_bot;
                if (setup_cnt_en) begin
                    state_d.ctx[i].cnt = setup_cnt;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign setup_err = state_q.err;

    // Assertions
    for (genvar g = 0; g < NUM_CTX; g++) begin : g_chk
        AST_TAKEN_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
            (redirect && next_pc == state_q.ctx[g].top && fetch_pc == state_q.ctx[g].bot
             && state_q.ctx[g].cnt != '0 && (g == NUM_CTX-1 || fetch_pc != state_q.ctx[NUM_CTX-1].bot
                 || state_q.ctx[NUM_CTX-1].cnt == '0) && !wr_en && !setup_valid)
            |=> state_q.ctx[g].cnt == $past(state_q.ctx[g].cnt) - CNT_W'(1)); // R2
    end

    AST_INNER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_pc == state_q.ctx[1].bot && state_q.ctx[1].cnt != '0)
        |-> (redirect && next_pc == state_q.ctx[1].top)); // R5

    AST_DEAD_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid
         && !(fetch_pc == state_q.ctx[0].bot && state_q.ctx[0].cnt != '0)
         && !(fetch_pc == state_q.ctx[1].bot && state_q.ctx[1].cnt != '0))
        |-> (!redirect && next_pc == fetch_pc + ADDR_W'(1))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !wr_en && !setup_valid)
        |=> $stable(state_q.ctx)); // R10

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && !setup_ok && !wr_en && !fetch_valid)
        |=> ($stable(state_q.ctx) && setup_err)); // R8

    AST_NO_REDIRECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !redirect); // R10

endmodule

// File: tb/tb_hwloop_ctrl.sv
module tb_hwloop_ctrl;
    import hwloop_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic [15:0] next_pc;
    logic        redirect;
    logic        setup_valid = 1'b0;
    logic [0:0]  setup_idx = '0;
    logic [15:0] setup_pc = '0, setup_top = '0, setup_bot = '0;
    logic        setup_cnt_en = 1'b0;
    logic [15:0] setup_cnt = '0;
    logic        setup_err;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_idx = '0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;

    int checks = 0;
    int errors = 0;
    logic pend_err = 1'b0;
    bit   done = 1'b0;

    typedef struct {
        logic [15:0] nxt;
        logic        rd;
        logic        er;
        string       tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #2 clk = ~clk;

    hwloop_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .next_pc(next_pc), .redirect(redirect),
        .setup_valid(setup_valid), .setup_idx(setup_idx), .setup_pc(setup_pc),
        .setup_top(setup_top), .setup_bot(setup_bot),
        .setup_cnt_en(setup_cnt_en), .setup_cnt(setup_cnt), .setup_err(setup_err),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    // Monitor: compares outputs against queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (next_pc !== e.nxt || redirect !== e.rd || setup_err !== e.er) begin
                    errors++;
                    $display("FAIL %s: next_pc=%h exp %h redirect=%b exp %b setup_err=%b exp %b",
                             e.tag, next_pc, e.nxt, redirect, e.rd, setup_err, e.er);
                end
            end
        end
    end

    task automatic push(input logic [15:0] nxt, input logic rd, input string tag);
        exp_t x;
        x.nxt = nxt; x.rd = rd; x.er = pend_err; x.tag = tag;
        q.push_back(x);
        pend_err = 1'b0;
    endtask

    task automatic clr();
        fetch_valid = 1'b0; setup_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_fetch(input logic fv, input logic [15:0] pc,
                            input logic [15:0] nxt, input logic rd, input string tag);
        @(negedge clk);
        clr();
        fetch_valid = fv; fetch_pc = pc;
        push(nxt, rd, tag);
    endtask

    task automatic do_fetch_wr(input logic [15:0] pc, input logic idx, input logic [1:0] s,
                               input logic [15:0] d, input logic [15:0] nxt, input logic rd,
                               input string tag);
        @(negedge clk);
        clr();
        fetch_valid = 1'b1; fetch_pc = pc;
        wr_en = 1'b1; wr_idx = idx; wr_sel = s; wr_data = d;
        push(nxt, rd, tag);
    endtask

    task automatic do_setup(input logic idx, input logic [15:0] pc, input logic [15:0] top,
                            input logic [15:0] bot, input logic ce, input logic [15:0] cnt,
                            input logic rej, input string tag);
        @(negedge clk);
        clr();
        fetch_pc = 16'h0000;
        setup_valid = 1'b1; setup_idx = idx; setup_pc = pc; setup_top = top;
        setup_bot = bot; setup_cnt_en = ce; setup_cnt = cnt;
        push(16'h0001, 1'b0, tag);
        pend_err = rej;
    endtask

    task automatic do_write(input logic idx, input logic [1:0] s, input logic [15:0] d,
                            input string tag);
        @(negedge clk);
        clr();
        fetch_pc = 16'h0000;
        wr_en = 1'b1; wr_idx = idx; wr_sel = s; wr_data = d;
        push(16'h0001, 1'b0, tag);
    endtask

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, counts zero so address 0 falls through
        do_fetch(1, 16'h0000, 16'h0001, 0, "R1 reset bottom zero");
        do_fetch(1, 16'h1234, 16'h1235, 0, "R1 reset sequential");

        // R7 / R2 / R3: setup with count, two loop-backs then exit
        do_setup(0, 16'h0100, 16'h0101, 16'h0104, 1, 16'd2, 0, "R7 setup accepted");
        do_fetch(1, 16'h0101, 16'h0102, 0, "R2 body sequential");
        do_fetch(1, 16'h0104, 16'h0101, 1, "R2 loop-back 1");
        do_fetch(1, 16'h0104, 16'h0101, 1, "R2 loop-back 2");
        do_fetch(1, 16'h0104, 16'h0105, 0, "R3 exit at zero");
        do_fetch(1, 16'h0104, 16'h0105, 0, "R3 stays idle");

        // R4: one-instruction loop
        do_setup(1, 16'h0200, 16'h0201, 16'h0201, 1, 16'd1, 0, "R4 setup");
        do_fetch(1, 16'h0201, 16'h0201, 1, "R4 single repeat");
        do_fetch(1, 16'h0201, 16'h0202, 0, "R4 single exit");

        // R7: setup without count keeps count
        do_write(1, WSEL_CNT, 16'd1, "R9 count write");
        do_setup(1, 16'h0200, 16'h0203, 16'h0205, 0, 16'd0, 0, "R7 setup no count");
        do_fetch(1, 16'h0205, 16'h0203, 1, "R7 count kept");
        do_fetch(1, 16'h0205, 16'h0206, 0, "R7 exit");

        // R9: selector 3 writes nothing; single-register writes
        do_write(1, WSEL_NONE, 16'd5, "R9 sel none");
        do_fetch(1, 16'h0205, 16'h0206, 0, "R9 sel none ignored");
        do_write(0, WSEL_TOP, 16'h0300, "R9 top write");
        do_write(0, WSEL_BOT, 16'h0302, "R9 bottom write");
        do_write(0, WSEL_CNT, 16'd1, "R9 count write");
        do_fetch(1, 16'h0302, 16'h0300, 1, "R9 written loop");
        do_fetch(1, 16'h0302, 16'h0303, 0, "R9 written exit");

        // R5: shared end address, inner first
        do_setup(0, 16'h0400, 16'h0401, 16'h0408, 1, 16'd1, 0, "R5 outer setup");
        do_setup(1, 16'h0404, 16'h0405, 16'h0408, 1, 16'd2, 0, "R5 inner setup");
        do_fetch(1, 16'h0408, 16'h0405, 1, "R5 inner 1");
        do_fetch(1, 16'h0408, 16'h0405, 1, "R5 inner 2");
        do_fetch(1, 16'h0408, 16'h0401, 1, "R5 outer after inner");
        do_fetch(1, 16'h0408, 16'h0409, 0, "R5 both done");

        // R6: different end addresses
        do_setup(0, 16'h0500, 16'h0501, 16'h0510, 1, 16'd1, 0, "R6 setup 0");
        do_setup(1, 16'h0500, 16'h0502, 16'h0506, 1, 16'd1, 0, "R6 setup 1");
        do_fetch(1, 16'h0506, 16'h0502, 1, "R6 ctx1 only");
        do_fetch(1, 16'h0510, 16'h0501, 1, "R6 ctx0 only");
        do_fetch(1, 16'h0506, 16'h0507, 0, "R6 ctx1 exit");
        do_fetch(1, 16'h0510, 16'h0511, 0, "R6 ctx0 exit");

        // R8: rejected setups
        do_write(0, WSEL_CNT, 16'd1, "R9 count write");
        do_setup(0, 16'h0600, 16'h0628, 16'h0650, 1, 16'd3, 1, "R8 top too far");
        do_fetch(1, 16'h0510, 16'h0501, 1, "R8 registers kept, err pulse");
        do_fetch(1, 16'h0510, 16'h0511, 0, "R8 err one cycle");
        do_setup(1, 16'h0600, 16'h0601, 16'h0A00, 1, 16'd1, 1, "R8 bottom too far");
        do_fetch(0, 16'h0000, 16'h0001, 0, "R8 err bottom span");
        do_setup(1, 16'h0600, 16'h0605, 16'h0603, 1, 16'd1, 1, "R8 bottom before top");
        do_fetch(0, 16'h0000, 16'h0001, 0, "R8 err order");
        do_setup(1, 16'h0600, 16'h0600, 16'h0604, 1, 16'd1, 1, "R8 top offset zero");
        do_fetch(1, 16'h0506, 16'h0507, 0, "R8 err zero offset, ctx1 kept");
        do_setup(1, 16'h0700, 16'h071F, 16'h0AFF, 1, 16'd1, 0, "R8 boundary accept");
        do_fetch(1, 16'h0AFF, 16'h071F, 1, "R8 boundary loop");
        do_fetch(1, 16'h0AFF, 16'h0B00, 0, "R8 boundary exit");

        // R10: invalid fetch does nothing
        do_write(1, WSEL_CNT, 16'd1, "R9 count write");
        do_fetch(0, 16'h0AFF, 16'h0B00, 0, "R10 invalid fetch");
        do_fetch(1, 16'h0AFF, 16'h071F, 1, "R10 count kept");
        do_fetch(1, 16'h0AFF, 16'h0B00, 0, "R10 exit");

        // R11: write beats decrement
        do_write(1, WSEL_CNT, 16'd2, "R9 count write");
        do_fetch_wr(16'h0AFF, 1, WSEL_CNT, 16'd0, 16'h071F, 1, "R11 loop with write");
        do_fetch(1, 16'h0AFF, 16'h0B00, 0, "R11 write won");

        @(negedge clk);
        clr();
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL monitor: %0d expectations left, expected 0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule